// File: doc/BRIEF.md
# 8-bit Logic and Increment ALU with Flag Register

This block is the arithmetic and logic slice of a small accumulator machine. Each cycle it takes a one-byte opcode, the accumulator, the value of the register that the opcode names and a valid strobe. It then works out one of six operations:

- OR with the accumulator
- XOR with the accumulator
- compare against the accumulator
- increment of a register
- decrement of a register
- one's complement of the accumulator

The result, the write enable and the destination are combinational. The six-bit flag set is held in a register inside the block. That register loads on a clock edge only when the strobe marks a recognised instruction.

Every operation has its own rules for each flag: it sets it, clears it, or leaves it as it was. A single flag bit carries two meanings. After a logic operation it shows even parity, and after an arithmetic operation it shows signed overflow. A compare updates the flags but writes no result. The surrounding datapath owns the register file, the fetch and memory operands. It supplies the operand on `reg_i` and applies the write that the block requests.

Top module: `alu8_flags`

## Requirements
- R1: OR (opcode 10110rrr) drives result = acc | reg with wr_en high and dest_acc high. The flags load with S = result bit 7, Z = (result == 0) and P/V = 1 when the result has an even number of ones. H, N and C are cleared.
- R2: XOR (opcode 10101rrr) drives result = acc ^ reg. Its write enable, destination and flag rules are the same as for OR.
- R3: Compare (opcode 10111rrr) forms acc − reg and keeps wr_en low. The flags load as follows: S and Z come from the difference, and N = 1. H = 1 on a borrow out of bits 3..0. P/V = 1 on a signed two's-complement overflow. C = 1 when reg > acc as unsigned values.
- R4: Increment (opcode 00rrr100) drives result = reg + 1 with dest_acc low. S and Z come from the result. H = 1 when the operand's low nibble was 0xF, and P/V = 1 only when the operand was 0x7F. N is cleared and C keeps its previous value.
- R5: Decrement (opcode 00rrr101) drives result = reg − 1 with dest_acc low. S and Z come from the result. H = 1 when the operand's low nibble was 0x0, and P/V = 1 only when the operand was 0x80. N is set and C keeps its previous value.
- R6: Complement (opcode 0x2F) drives result = ~acc with wr_en and dest_acc high. It sets H and N and keeps S, Z, P/V and C at their previous values.
- R7: When the operand field of a decoded opcode equals 110 (memory operand), unsupported_o goes high and wr_en stays low. The flags keep their value. The operand field is bits 2..0 for OR, XOR and compare, and bits 5..3 for increment and decrement.
- R8: With valid_i low, or with an opcode outside the six operations, wr_en stays low and the flags keep their value.
- R9: flags_o is ordered S, Z, 0, H, 0, P/V, N, C from bit 7 down to bit 0, and bits 5 and 3 always read 0. When rst_n is low at a clock edge, flags_o becomes 0x00.
- R10: reg_sel_o always equals opcode bits 5..3. For increment and decrement it names the register to write back, with codes 000 to 111 meaning B, C, D, E, H, L, memory, A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the flag register |
| valid_i | input | 1 | Instruction strobe; qualifies write and flag load |
| opcode_i | input | 8 | Instruction byte |
| acc_i | input | 8 | Accumulator value |
| reg_i | input | 8 | Value of the register named by the opcode |
| result_o | output | 8 | Operation result |
| wr_en_o | output | 1 | Request to write result_o to the destination |
| dest_acc_o | output | 1 | 1: destination is the accumulator, 0: register reg_sel_o |
| reg_sel_o | output | 3 | Register code for write-back (opcode bits 5..3) |
| unsupported_o | output | 1 | Memory-operand form decoded; nothing done |
| flags_o | output | 8 | Registered flags S,Z,0,H,0,P/V,N,C |

## Verification
Two things happen on the same strobe: the result is written back and the flags load. Several of the flag bits load while others keep their old value. The bench sets the carry with a compare that borrows, then runs increments and decrements straight after it. On the same edge it checks the new result and H, P/V and N, and that C still holds the value the compare left. Complement is checked the same way against a P/V bit that an earlier OR had set, and every expected flag byte is worked out from the requirement rules.

// File: rtl/alu8_pkg.sv
// Package: shared widths, flag bit positions and the decoded operation type.
// Assumes an 8-bit datapath; the flag positions are fixed by the layout in R9.
package alu8_pkg;
    localparam int DW      = 8;
    localparam int FW      = 8;
    localparam int RSEL_W  = 3;
    localparam int FLG_S   = 7;
    localparam int FLG_Z   = 6;
    localparam int FLG_H   = 4;
    localparam int FLG_PV  = 2;
    localparam int FLG_N   = 1;
    localparam int FLG_C   = 0;
    localparam logic [FW-1:0] FLG_USED = 8'b1101_0111;
    localparam logic [RSEL_W-1:0] MEM_CODE = 3'b110;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_OR   = 3'd1,
        OP_XOR  = 3'd2,
        OP_CP   = 3'd3,
        OP_INC  = 3'd4,
        OP_DEC  = 3'd5,
        OP_CPL  = 3'd6
    } alu_op_e;
endpackage

// File: rtl/alu8_decode.sv
// Decoder: maps the opcode byte to an operation, its destination and the
// memory-operand marker. Assumes the opcode is stable while valid is high.
module alu8_decode
    import alu8_pkg::*;
(
    input  logic [7:0]        opcode,
    output alu_op_e           op,
    output logic              mem_operand,
    output logic              to_acc,
    output logic [RSEL_W-1:0] reg_sel
);
    // Purpose: classify the opcode and pick the operand field it uses.
    always_comb begin
        op          = OP_NONE;
        mem_operand = 1'b0;
        to_acc      = 1'b0;
        reg_sel     = opcode[5:3];
        if (opcode == 8'h2F) begin
            op     = OP_CPL;
            to_acc = 1'b1;
        end else if (opcode[7:3] == 5'b10110) begin
            op          = OP_OR;
            to_acc      = 1'b1;
            mem_operand = (opcode[2:0] == MEM_CODE);
        end else if (opcode[7:3] == 5'b10101) begin
            op          = OP_XOR;
            to_acc      = 1'b1;
            mem_operand = (opcode[2:0] == MEM_CODE);
        end else if (opcode[7:3] == 5'b10111) begin
            op          = OP_CP;
            mem_operand = (opcode[2:0] == MEM_CODE);
        end else if (opcode[7:6] == 2'b00 && opcode[2:0] == 3'b100) begin
            op          = OP_INC;
            mem_operand = (opcode[5:3] == MEM_CODE);
        end else if (opcode[7:6] == 2'b00 && opcode[2:0] == 3'b101) begin
            op          = OP_DEC;
            mem_operand = (opcode[5:3] == MEM_CODE);
        end
    end
endmodule

// File: rtl/alu8_exec.sv
// Execution unit: computes the result, the result-write request and the next
// flag byte from the decoded operation. Flags an operation leaves alone are
// copied from flags_cur. Purely combinational.
module alu8_exec
    import alu8_pkg::*;
(
    input  alu_op_e        op,
    input  logic [DW-1:0]  acc,
    input  logic [DW-1:0]  opnd,
    input  logic [FW-1:0]  flags_cur,
    output logic [DW-1:0]  result,
    output logic           writes,
    output logic [FW-1:0]  flags_nxt
);
    logic [DW:0]   diff;
    logic [DW-1:0] res;

    // Purpose: form the result and the per-operation flag rules.
    always_comb begin
        diff      = {1'b0, acc} - {1'b0, opnd};
        res       = '0;
        writes    = 1'b0;
        flags_nxt = flags_cur;
        unique case (op)
            OP_OR, OP_XOR: begin
                res               = (op == OP_OR) ? (acc | opnd) : (acc ^ opnd);
                writes            = 1'b1;
                flags_nxt[FLG_PV] = ~^res;
                flags_nxt[FLG_H]  = 1'b0;
                flags_nxt[FLG_N]  = 1'b0;
                flags_nxt[FLG_C]  = 1'b0;
            end
            OP_CP: begin
                res               = diff[DW-1:0];
                flags_nxt[FLG_H]  = (acc[3:0] < opnd[3:0]);
                flags_nxt[FLG_PV] = (acc[DW-1] != opnd[DW-1]) && (res[DW-1] != acc[DW-1]);
                flags_nxt[FLG_N]  = 1'b1;
                flags_nxt[FLG_C]  = diff[DW];
            end
            OP_INC: begin
                res               = opnd + 1'b1;
                writes            = 1'b1;
                flags_nxt[FLG_H]  = (opnd[3:0] == 4'hF);
                flags_nxt[FLG_PV] = (opnd == 8'h7F);
                flags_nxt[FLG_N]  = 1'b0;
            end
            OP_DEC: begin
                res               = opnd - 1'b1;
                writes            = 1'b1;
                flags_nxt[FLG_H]  = (opnd[3:0] == 4'h0);
                flags_nxt[FLG_PV] = (opnd == 8'h80);
                flags_nxt[FLG_N]  = 1'b1;
            end
            OP_CPL: begin
                res              = ~acc;
                writes           = 1'b1;
                flags_nxt[FLG_H] = 1'b1;
                flags_nxt[FLG_N] = 1'b1;
            end
            default: begin
                res    = '0;
                writes = 1'b0;
            end
        endcase
        if (op != OP_CPL && op != OP_NONE) begin
            flags_nxt[FLG_S] = res[DW-1];
            flags_nxt[FLG_Z] = (res == '0);
        end
        flags_nxt = flags_nxt & FLG_USED;
        result    = res;
    end
endmodule

// File: rtl/alu8_flag_reg.sv
// Flag register: holds S,Z,0,H,0,P/V,N,C. Loads d when load is high; a low
// rst_n at a clock edge clears it. Assumes load is already qualified.
module alu8_flag_reg
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FW-1:0] d,
    output logic [FW-1:0] q
);
    // Purpose: store the flag byte under reset and load control.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d & FLG_USED;
    end

    AST_FLAGS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q)); // R8
    AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (q[5] == 1'b0) && (q[3] == 1'b0)); // R9
endmodule

// File: rtl/alu8_flags.sv
// Top: decode, execute and flag storage for the 8-bit ALU slice. Result and
// write request are combinational; flags are registered on a valid strobe.
// Assumes reg_i already carries the register named by the opcode.
module alu8_flags
    import alu8_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid_i,
    input  logic [7:0]  opcode_i,
    input  logic [7:0]  acc_i,
    input  logic [7:0]  reg_i,
    output logic [7:0]  result_o,
    output logic        wr_en_o,
    output logic        dest_acc_o,
    output logic [2:0]  reg_sel_o,
    output logic        unsupported_o,
    output logic [7:0]  flags_o
);
    alu_op_e        op;
    logic           mem_op;
    logic           to_acc;
    logic           writes;
    logic [FW-1:0]  flags_nxt;
    logic           flag_load;

    alu8_decode u_dec (
        .opcode      (opcode_i),
        .op          (op),
        .mem_operand (mem_op),
        .to_acc      (to_acc),
        .reg_sel     (reg_sel_o)
    );

    alu8_exec u_exe (
        .op        (op),
        .acc       (acc_i),
        .opnd      (reg_i),
        .flags_cur (flags_o),
        .result    (result_o),
        .writes    (writes),
        .flags_nxt (flags_nxt)
    );

    // Purpose: gate write and flag load with the strobe and memory marker.
    always_comb begin
        wr_en_o       = valid_i && writes && !mem_op;
        dest_acc_o    = to_acc;
        unsupported_o = valid_i && mem_op;
        flag_load     = valid_i && !mem_op && (op != OP_NONE);
    end

    alu8_flag_reg u_flg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (flag_load),
        .d     (flags_nxt),
        .q     (flags_o)
    );

    AST_CP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && opcode_i[7:3] == 5'b10111) |-> !wr_en_o); // R3
    AST_INC_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && opcode_i[7:6] == 2'b00 && opcode_i[2:0] == 3'b100)
        |=> flags_o[FLG_C] == $past(flags_o[FLG_C])); // R4
    AST_DEC_SETS_N: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !unsupported_o && opcode_i[7:6] == 2'b00 && opcode_i[2:0] == 3'b101)
        |=> flags_o[FLG_N]); // R5
    AST_MEM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported_o |-> !wr_en_o); // R7
    AST_MEM_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported_o |=> $stable(flags_o)); // R7
endmodule

// File: tb/sim_alu8_flags.sv
module sim_alu8_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid_i = 1'b0;
    logic [7:0] opcode_i = 8'h00;
    logic [7:0] acc_i = 8'h00;
    logic [7:0] reg_i = 8'h00;
    logic [7:0] result_o;
    logic       wr_en_o;
    logic       dest_acc_o;
    logic [2:0] reg_sel_o;
    logic       unsupported_o;
    logic [7:0] flags_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    alu8_flags u0 (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .opcode_i(opcode_i),
        .acc_i(acc_i), .reg_i(reg_i), .result_o(result_o), .wr_en_o(wr_en_o),
        .dest_acc_o(dest_acc_o), .reg_sel_o(reg_sel_o),
        .unsupported_o(unsupported_o), .flags_o(flags_o)
    );

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    // Issue one instruction, check combinational outputs, then flags after the edge.
    task automatic run(string req, logic vld, logic [7:0] opc, logic [7:0] a,
                       logic [7:0] r, logic [7:0] e_res, logic e_we,
                       logic e_dacc, logic e_uns, logic [7:0] e_flg);
        @(negedge clk);
        valid_i = vld; opcode_i = opc; acc_i = a; reg_i = r;
        #1;
        if (e_we) chk(req, "result", result_o, e_res);
        chk(req, "wr_en", {7'd0, wr_en_o}, {7'd0, e_we});
        if (e_we) chk(req, "dest_acc", {7'd0, dest_acc_o}, {7'd0, e_dacc});
        chk(req, "unsupported", {7'd0, unsupported_o}, {7'd0, e_uns});
        chk(req, "reg_sel", {5'd0, reg_sel_o}, {5'd0, opc[5:3]});
        @(negedge clk);
        valid_i = 1'b0;
        chk(req, "flags", flags_o, e_flg);
    endtask

    task automatic t_reset();
        chk("R9", "flags after reset", flags_o, 8'h00);
    endtask

    task automatic t_or();
        run("R1", 1'b1, 8'hB0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 8'h44);
        run("R1", 1'b1, 8'hB1, 8'h80, 8'h01, 8'h81, 1'b1, 1'b1, 1'b0, 8'h84);
    endtask

    task automatic t_xor();
        run("R2", 1'b1, 8'hAA, 8'h55, 8'h54, 8'h01, 1'b1, 1'b1, 1'b0, 8'h00);
        run("R2", 1'b1, 8'hAF, 8'hFF, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, 8'h44);
    endtask

    task automatic t_cp();
        run("R3", 1'b1, 8'hB8, 8'h05, 8'h05, 8'h00, 1'b0, 1'b0, 1'b0, 8'h42);
        run("R3", 1'b1, 8'hB9, 8'h10, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 8'h12);
        run("R3", 1'b1, 8'hBA, 8'h80, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 8'h16);
        run("R3", 1'b1, 8'hBB, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 8'h93);
    endtask

    // Carry is 1 from the last compare; INC/DEC must keep it.
    task automatic t_inc();
        run("R4", 1'b1, 8'h04, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0, 8'h51);
        run("R4", 1'b1, 8'h1C, 8'h00, 8'h0F, 8'h10, 1'b1, 1'b0, 1'b0, 8'h11);
        run("R4", 1'b1, 8'h3C, 8'h00, 8'h7F, 8'h80, 1'b1, 1'b0, 1'b0, 8'h95);
    endtask

    task automatic t_dec();
        run("R5", 1'b1, 8'h15, 8'h00, 8'h80, 8'h7F, 1'b1, 1'b0, 1'b0, 8'h17);
        run("R5", 1'b1, 8'h0D, 8'h00, 8'h01, 8'h00, 1'b1, 1'b0, 1'b0, 8'h43);
        run("R1", 1'b1, 8'hB0, 8'h01, 8'h02, 8'h03, 1'b1, 1'b1, 1'b0, 8'h04);
        run("R5", 1'b1, 8'h05, 8'h00, 8'h00, 8'hFF, 1'b1, 1'b0, 1'b0, 8'h92);
    endtask

    task automatic t_cpl();
        run("R1", 1'b1, 8'hB0, 8'h01, 8'h02, 8'h03, 1'b1, 1'b1, 1'b0, 8'h04);
        run("R6", 1'b1, 8'h2F, 8'h5A, 8'h00, 8'hA5, 1'b1, 1'b1, 1'b0, 8'h16);
    endtask

    task automatic t_mem();
        run("R7", 1'b1, 8'hB6, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 8'h16);
        run("R7", 1'b1, 8'h34, 8'h00, 8'h7F, 8'h00, 1'b0, 1'b0, 1'b1, 8'h16);
        run("R7", 1'b1, 8'hBE, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0, 1'b1, 8'h16);
    endtask

    task automatic t_idle();
        run("R8", 1'b1, 8'h00, 8'hFF, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 8'h16);
        run("R8", 1'b0, 8'hB0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 8'h16);
    endtask

    task automatic t_dest();
        // R10: the write-back register code comes from opcode bits 5..3
        run("R10", 1'b1, 8'h3D, 8'h00, 8'h02, 8'h01, 1'b1, 1'b0, 1'b0, 8'h02);
    endtask

    task automatic t_reset_again();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R9", "flags after second reset", flags_o, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_or();
        t_xor();
        t_cp();
        t_inc();
        t_dec();
        t_cpl();
        t_mem();
        t_idle();
        t_dest();
        t_reset_again();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual running expected done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule